// File: doc/BRIEF.md
# Cycle-Stealing Video RAM Arbiter

This block lets a slow processor bus write into a video memory that lives in the much faster pixel clock domain. It latches each processor write and passes it across the clock boundary with a toggle handshake. In the pixel domain it then gives the single-port video RAM to that write for exactly one pixel cycle. The processor always has priority. On every other cycle the RAM fetches the next display word.

A pixel cycle taken by a write produces no new display word. For that cycle the block holds the last fetched pixel on its output instead of a blank value. The display scan address moves forward only on cycles that really fetched. A processor write is taken only when its upper address bits select the video window and the previous write has finished its round trip. While a write is in flight, the block raises a busy flag and ignores further writes.

Top module: `vram_steal_arb`

## Requirements
- R1: While reset is held, pix_out is 0, vram_we is 0 and vram_addr is 0. After reset, with no transfer in flight, cpu_busy is 0.
- R2: A write is taken at a rising edge of cpu_clk where cpu_rd is 0, cpu_busy is 0, and cpu_addr[31:12] equals the upper bits of the window base, which defaults to 32'h0010_0000. From the next cpu_clk edge onward, cpu_busy is 1 and the captured address and data stay unchanged until cpu_busy falls.
- R3: A write attempted while cpu_busy is 1 is ignored. It never reaches the RAM.
- R4: A write whose upper address bits miss the window is ignored. cpu_busy stays 0.
- R5: A cycle with cpu_rd at 1 has no effect on the RAM or on cpu_busy.
- R6: Each taken write produces exactly one pixel cycle with vram_we at 1. In that cycle vram_addr equals cpu_addr[11:0] of the write and vram_wdata equals its data.
- R7: On cycles with vram_we at 0, vram_addr is the scan address. It starts at 0 after reset and rises by 1 per fetch cycle. After FRAME_WORDS-1 (default 63) it wraps to 0. A write cycle leaves it unchanged.
- R8: The RAM returns read data one pix_clk edge after the address. pix_out shows that word one edge later. When the cycle two edges back was a write, pix_out repeats its previous value. After reset, pix_out is never unknown.
- R9: Once the write has reached the RAM and the acknowledge is back, cpu_busy returns to 0. The next write is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor bus clock |
| cpu_rst_n | input | 1 | Active-low reset, processor domain |
| cpu_addr | input | 32 | Processor address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rd | input | 1 | High for a read cycle, low for a write cycle |
| cpu_busy | output | 1 | A taken write has not yet been acknowledged |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| vram_addr | output | 12 | Video RAM word address |
| vram_we | output | 1 | Video RAM write enable |
| vram_wdata | output | 32 | Video RAM write data |
| vram_rdata | input | 32 | Video RAM read data, valid one edge after the address |
| pix_out | output | 32 | Pixel word stream |

## Verification
The bench walks a mix of patterns:
- in-window writes to distinct words and to the frame's last word;
- a write outside the window;
- a read cycle carrying a valid address;
- a second write issued while the first is still in flight.

These separate the window decode, the busy gate and the cpu_rd polarity. A free-running monitor rebuilds the expected pixel stream from the RAM traffic it sees. This shows whether stolen cycles repeat the previous pixel rather than dropping or shifting one. It also shows whether the scan address skips a word during a write. A final comparison of the whole RAM against a reference model catches lost, duplicated or misdirected writes.

// File: rtl/vram_steal_arb.sv
module vram_steal_arb #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VAW = 12,
  parameter int FRAME_WORDS = 64,
  parameter logic [AW-1:0] VBASE = 32'h0010_0000
) (
  input  logic           cpu_clk,
  input  logic           cpu_rst_n,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  input  logic           cpu_rd,
  output logic           cpu_busy,
  input  logic           pix_clk,
  input  logic           pix_rst_n,
  output logic [VAW-1:0] vram_addr,
  output logic           vram_we,
  output logic [DW-1:0]  vram_wdata,
  input  logic [DW-1:0]  vram_rdata,
  output logic [DW-1:0]  pix_out
);
  localparam logic [VAW-1:0] LAST = VAW'(FRAME_WORDS - 1);

  logic           req_tgl, ack_tgl;
  logic [1:0]     ack_s, req_s;
  logic [VAW-1:0] wr_addr_q, scan_addr;
  logic [DW-1:0]  wr_data_q;
  logic           fetch_q;

  wire hit  = cpu_addr[AW-1:VAW] == VBASE[AW-1:VAW];
  wire take = !cpu_rd && hit && !cpu_busy;
  wire pend = req_s[1] ^ ack_tgl;

  assign cpu_busy   = req_tgl ^ ack_s[1];
  assign vram_we    = pend;
  assign vram_addr  = pend ? wr_addr_q : scan_addr;
  assign vram_wdata = wr_data_q;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      req_tgl   <= 1'b0;
      ack_s     <= 2'b00;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      ack_s <= {ack_s[0], ack_tgl};
      if (take) begin
        req_tgl   <= ~req_tgl;
        wr_addr_q <= cpu_addr[VAW-1:0];
        wr_data_q <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) begin
      req_s     <= 2'b00;
      ack_tgl   <= 1'b0;
      scan_addr <= '0;
      fetch_q   <= 1'b0;
      pix_out   <= '0;
    end else begin
      req_s   <= {req_s[0], req_tgl};
      fetch_q <= !pend;
      if (pend) ack_tgl <= req_s[1];
      else      scan_addr <= (scan_addr == LAST) ? '0 : scan_addr + 1'b1;
      if (fetch_q) pix_out <= vram_rdata;
    end
  end
endmodule

// File: rtl/vram_steal_arb_chk.sv
module vram_steal_arb_chk #(
  parameter int DW = 32,
  parameter int VAW = 12
) (
  input logic           cpu_clk,
  input logic           cpu_rst_n,
  input logic           pix_clk,
  input logic           pix_rst_n,
  input logic           cpu_busy,
  input logic [VAW-1:0] wr_addr_q,
  input logic [DW-1:0]  wr_data_q,
  input logic           vram_we,
  input logic [VAW-1:0] scan_addr,
  input logic           fetch_q,
  input logic [DW-1:0]  pix_out
);
  a_r2_hold_capture: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_busy && $past(cpu_busy)) |-> ($stable(wr_addr_q) && $stable(wr_data_q)));

  a_r6_single_write: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    vram_we |=> !vram_we);

  a_r7_scan_hold: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    vram_we |=> $stable(scan_addr));

  a_r8_repeat_pixel: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    !fetch_q |=> $stable(pix_out));

  a_r8_no_x: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    !$isunknown(pix_out));
endmodule

bind vram_steal_arb vram_steal_arb_chk #(.DW(DW), .VAW(VAW)) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
  .cpu_busy(cpu_busy), .wr_addr_q(wr_addr_q), .wr_data_q(wr_data_q),
  .vram_we(vram_we), .scan_addr(scan_addr), .fetch_q(fetch_q), .pix_out(pix_out));

// File: tb/vram_steal_arb_tb.sv
module vram_steal_arb_tb;
  localparam int VAW = 12;
  localparam int FW = 64;

  logic cpu_clk = 0, pix_clk = 0, cpu_rst_n = 0, pix_rst_n = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_rd = 1;
  logic cpu_busy, vram_we;
  logic [VAW-1:0] vram_addr;
  logic [31:0] vram_wdata, pix_out;
  logic [31:0] vram_rdata = 0;

  always #2 pix_clk = ~pix_clk;
  always #26 cpu_clk = ~cpu_clk;

  vram_steal_arb u_dut (.cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_busy(cpu_busy), .pix_clk(pix_clk),
    .pix_rst_n(pix_rst_n), .vram_addr(vram_addr), .vram_we(vram_we),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata), .pix_out(pix_out));

  logic [31:0] ram [2**VAW];
  logic [31:0] ref_mem [2**VAW];
  initial for (int i = 0; i < 2**VAW; i++) begin ram[i] = i * 3 + 1; ref_mem[i] = i * 3 + 1; end
  always @(posedge pix_clk)
    if (vram_we) ram[vram_addr] <= vram_wdata;
    else         vram_rdata <= ram[vram_addr];

  int checks = 0, errors = 0, accepted = 0, we_seen = 0;
  logic [VAW-1:0] last_addr;
  logic [31:0] last_data;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  // pixel-domain monitor: R6 R7 R8
  int mon_n = 0;
  logic we_d1, we_d2;
  logic [31:0] rd_d1, pix_d1;
  logic [VAW-1:0] exp_scan = 1;
  always @(negedge pix_clk) if (pix_rst_n && !done) begin
    if (vram_we) begin
      we_seen++;
      chk(vram_addr == last_addr, "R6 addr", 32'(vram_addr), 32'(last_addr));
      chk(vram_wdata == last_data, "R6 data", vram_wdata, last_data);
    end else begin
      chk(vram_addr == exp_scan, "R7 scan", 32'(vram_addr), 32'(exp_scan));
      exp_scan = (exp_scan == VAW'(FW - 1)) ? '0 : exp_scan + 1'b1;
    end
    chk(!$isunknown(pix_out), "R8 no X", pix_out, 32'h0);
    if (mon_n >= 2) begin
      if (!we_d2) chk(pix_out === rd_d1, "R8 fetch", pix_out, rd_d1);
      else        chk(pix_out === pix_d1, "R8 repeat", pix_out, pix_d1);
    end
    we_d2 = we_d1; we_d1 = vram_we; rd_d1 = vram_rdata; pix_d1 = pix_out;
    mon_n++;
  end

  int cyc = 0;
  always @(posedge pix_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 200 && cpu_busy; i++) @(negedge cpu_clk);
  endtask

  task automatic cpu_op(input bit rd, input logic [31:0] a, input logic [31:0] d, input bit exp_take);
    @(negedge cpu_clk);
    cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    if (exp_take) begin last_addr = a[VAW-1:0]; last_data = d; end
    @(negedge cpu_clk);
    cpu_rd = 1;
    if (exp_take) begin ref_mem[a[VAW-1:0]] = d; accepted++; end
  endtask

  // {rd, addr, data, expect_taken}
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 32'h0010_0005, 32'hA5A5_0001, 1'b1},
    {1'b0, 32'h0010_0006, 32'h5A5A_0002, 1'b1},
    {1'b0, 32'h0020_0007, 32'hDEAD_0003, 1'b0},
    {1'b1, 32'h0010_0008, 32'hBEEF_0004, 1'b0},
    {1'b0, 32'h0010_003F, 32'h1234_5678, 1'b1},
    {1'b0, 32'h0010_0000, 32'hFFFF_FFFF, 1'b1},
    {1'b0, 32'h0011_0009, 32'h0BAD_0005, 1'b0},
    {1'b0, 32'h0010_0005, 32'h0000_0000, 1'b1}
  };

  initial begin
    #7;
    // R1 reset state
    chk(pix_out == 0, "R1 pix_out", pix_out, 0);
    chk(vram_we == 0, "R1 vram_we", 32'(vram_we), 0);
    chk(vram_addr == 0, "R1 vram_addr", 32'(vram_addr), 0);
    @(negedge pix_clk); #1 pix_rst_n = 1;
    @(negedge cpu_clk); cpu_rst_n = 1;
    @(negedge cpu_clk);
    chk(cpu_busy == 0, "R1 busy", 32'(cpu_busy), 0);

    foreach (VEC[i]) begin
      wait_idle();
      cpu_op(VEC[i][65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
      if (VEC[i][0]) chk(cpu_busy == 1, "R2 busy after take", 32'(cpu_busy), 1);
      else chk(cpu_busy == 0, VEC[i][65] ? "R5 read ignored" : "R4 out of window", 32'(cpu_busy), 0);
    end

    // R3: second write while busy is dropped; R9: accepted once idle
    wait_idle();
    cpu_op(0, 32'h0010_0010, 32'hCAFE_0010, 1);
    chk(cpu_busy == 1, "R3 busy", 32'(cpu_busy), 1);
    @(negedge cpu_clk); cpu_rd = 0; cpu_addr = 32'h0010_0011; cpu_wdata = 32'h7777_7777;
    @(negedge cpu_clk); cpu_rd = 1;
    wait_idle();
    chk(cpu_busy == 0, "R9 busy clears", 32'(cpu_busy), 0);
    cpu_op(0, 32'h0010_0012, 32'hCAFE_0012, 1);
    chk(cpu_busy == 1, "R9 next taken", 32'(cpu_busy), 1);
    wait_idle();
    repeat (FW * 3) @(negedge pix_clk);

    chk(ram[12'h011] == ref_mem[12'h011], "R3 dropped write", ram[12'h011], ref_mem[12'h011]);
    chk(we_seen == accepted, "R6 write count", 32'(we_seen), 32'(accepted));
    begin
      int bad = 0;
      for (int i = 0; i < 2**VAW; i++) if (ram[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R2 R4 R5 memory image", 32'(bad), 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule